// File: doc/BRIEF.md
# Issue Stage Occupancy Controller

This block keeps the books for the single issue slot of an in-order scalar core. Every instruction that enters the slot holds it for a fixed number of cycles, and that number depends on the instruction's class. The block decodes the class into an occupancy, loads a down-counter with it, and stalls the fetch side until the counter has drained. Data paths, operand hazards and execution units are not modelled here. The block only accounts for slot occupancy.

The fetch side drives a valid strobe, a 4-bit class code, a 4-bit word count for multi-word transfers, and a configuration bit that picks the slow multiplier. An instruction is taken in any cycle where `valid_i` and `ready_o` are both high. `busy_o` reports how many more cycles the slot stays closed after the accepting cycle. An instruction with occupancy K is therefore followed by K-1 cycles with `ready_o` low.

Top module: `issue_occ_ctrl`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `busy_o` is 0 and `ready_o` is 1. An asserted reset clears a slot that is still busy.
- R2: Class codes 0 (ALU), 1 (misc), 2 (branch), 3 (single load) and 4 (single store) occupy one cycle. With `valid_i` held high they are accepted back to back.
- R3: When `mul_slow_i`=0, class 5 (multiply) occupies 1 cycle and class 6 (multiply-accumulate) occupies 2 cycles.
- R4: When `mul_slow_i`=1, class 5 occupies 17 cycles and class 6 occupies 18 cycles.
- R5: Class 7 (divide) occupies 37 cycles for either value of `mul_slow_i`.
- R6: Class 8 (load multiple) and class 9 (store multiple) occupy `words_i` cycles when `words_i` is 1 to 8 or 12. Any other word count gives one cycle.
- R7: Class 10 (double load) and class 11 (double store) occupy 2 cycles whatever the value of `words_i`.
- R8: Class codes 12 to 15 are unknown and occupy one cycle, so the slot never locks up.
- R9: `ready_o` is low exactly while `busy_o` is nonzero. A `valid_i` presented in those cycles is ignored and does not change the count.
- R10: In the cycle after an instruction with occupancy K is accepted, `busy_o` equals K-1. It then falls by one every cycle until it reaches 0.
- R11: `mul_slow_i` is sampled only at acceptance. Changing it while the slot is busy does not alter the remaining count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is offered |
| class_i | input | 4 | Instruction class code |
| words_i | input | 4 | Word count of a multi-word transfer |
| mul_slow_i | input | 1 | 1 selects the slow multiplier timing |
| ready_o | output | 1 | Slot free; the offered instruction is taken this cycle |
| busy_o | output | 6 | Remaining closed cycles |

## Verification
The embedded assertions watch every cycle for several properties: the countdown by one, loading only into an idle slot, the K-1 value after an acceptance, the decoded occupancy being nonzero, and the fixed divide, single-cycle and slow-multiply decodes. Other behaviour can only be shown by the bench scenarios, which run against a behavioural model. These scenarios cover back-to-back single-cycle streams, the full sweep of legal and illegal word counts, the double-word case ignoring the count, `valid_i` being ignored while busy, a configuration flip in the middle of an occupancy, and a reset that lands while the slot is busy.

// File: rtl/issue_occ_pkg.sv
package issue_occ_pkg;
  typedef enum logic [3:0] {
    CLS_ALU    = 4'd0,
    CLS_MISC   = 4'd1,
    CLS_BRANCH = 4'd2,
    CLS_LOAD   = 4'd3,
    CLS_STORE  = 4'd4,
    CLS_MUL    = 4'd5,
    CLS_MAC    = 4'd6,
    CLS_DIV    = 4'd7,
    CLS_LDM    = 4'd8,
    CLS_STM    = 4'd9,
    CLS_LDD    = 4'd10,
    CLS_STD    = 4'd11
  } iclass_e;
endpackage

// File: rtl/issue_occ_lut.sv
module issue_occ_lut
  import issue_occ_pkg::*;
#(
  parameter int WORDS_W      = 4,
  parameter int OCC_W        = 6,
  parameter int MUL_FAST_CYC = 1,
  parameter int MAC_FAST_CYC = 2,
  parameter int MUL_SLOW_CYC = 17,
  parameter int MAC_SLOW_CYC = 18,
  parameter int DIV_CYC      = 37,
  parameter int DBL_CYC      = 2,
  parameter int MAX_WORDS    = 8,
  parameter int WIDE_WORDS   = 12
) (
  input  logic [3:0]         class_i,
  input  logic [WORDS_W-1:0] words_i,
  input  logic               mul_slow_i,
  output logic [OCC_W-1:0]   occ_o
);
  localparam logic [OCC_W-1:0]   OneC    = OCC_W'(1);
  localparam logic [OCC_W-1:0]   MulFast = OCC_W'(MUL_FAST_CYC);
  localparam logic [OCC_W-1:0]   MacFast = OCC_W'(MAC_FAST_CYC);
  localparam logic [OCC_W-1:0]   MulSlow = OCC_W'(MUL_SLOW_CYC);
  localparam logic [OCC_W-1:0]   MacSlow = OCC_W'(MAC_SLOW_CYC);
  localparam logic [OCC_W-1:0]   DivC    = OCC_W'(DIV_CYC);
  localparam logic [OCC_W-1:0]   DblC    = OCC_W'(DBL_CYC);
  localparam logic [WORDS_W-1:0] WMin    = WORDS_W'(1);
  localparam logic [WORDS_W-1:0] WMax    = WORDS_W'(MAX_WORDS);
  localparam logic [WORDS_W-1:0] WWide   = WORDS_W'(WIDE_WORDS);

  logic words_ok;
  assign words_ok = ((words_i >= WMin) && (words_i <= WMax)) || (words_i == WWide);

  always_comb begin
    case (class_i)
      CLS_MUL:          occ_o = mul_slow_i ? MulSlow : MulFast;
      CLS_MAC:          occ_o = mul_slow_i ? MacSlow : MacFast;
      CLS_DIV:          occ_o = DivC;
      CLS_LDM, CLS_STM: occ_o = words_ok ? OCC_W'(words_i) : OneC;
      CLS_LDD, CLS_STD: occ_o = DblC;
      default:          occ_o = OneC;  // simple classes and unknown codes
    endcase
  end
endmodule

// File: rtl/issue_occ_cnt.sv
module issue_occ_cnt #(
  parameter int OCC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OCC_W-1:0] occ_i,
  output logic [OCC_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [OCC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= occ_i - OCC_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - OCC_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_DOWNCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - OCC_W'(1)); // R10
  AST_LOAD_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0); // R9
endmodule

// File: rtl/issue_occ_ctrl.sv
module issue_occ_ctrl
  import issue_occ_pkg::*;
#(
  parameter int WORDS_W      = 4,
  parameter int MUL_FAST_CYC = 1,
  parameter int MAC_FAST_CYC = 2,
  parameter int MUL_SLOW_CYC = 17,
  parameter int MAC_SLOW_CYC = 18,
  parameter int DIV_CYC      = 37,
  parameter int DBL_CYC      = 2,
  parameter int MAX_WORDS    = 8,
  parameter int WIDE_WORDS   = 12,
  localparam int OCC_W       = $clog2(DIV_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [3:0]         class_i,
  input  logic [WORDS_W-1:0] words_i,
  input  logic               mul_slow_i,
  output logic               ready_o,
  output logic [OCC_W-1:0]   busy_o
);
  logic [OCC_W-1:0] occ;
  logic             accept;
  logic             idle;

  issue_occ_lut #(
    .WORDS_W(WORDS_W), .OCC_W(OCC_W),
    .MUL_FAST_CYC(MUL_FAST_CYC), .MAC_FAST_CYC(MAC_FAST_CYC),
    .MUL_SLOW_CYC(MUL_SLOW_CYC), .MAC_SLOW_CYC(MAC_SLOW_CYC),
    .DIV_CYC(DIV_CYC), .DBL_CYC(DBL_CYC),
    .MAX_WORDS(MAX_WORDS), .WIDE_WORDS(WIDE_WORDS)
  ) u_lut (
    .class_i   (class_i),
    .words_i   (words_i),
    .mul_slow_i(mul_slow_i),
    .occ_o     (occ)
  );

  assign accept = valid_i && idle;

  issue_occ_cnt #(.OCC_W(OCC_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .occ_i (occ),
    .cnt_o (busy_o),
    .zero_o(idle)
  );

  assign ready_o = idle;

  AST_ACCEPT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> busy_o == $past(occ) - OCC_W'(1)); // R10
  AST_OCC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> occ != '0); // R8
  AST_DIV_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == CLS_DIV) |-> occ == OCC_W'(DIV_CYC)); // R5
  AST_SIMPLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i <= CLS_STORE) |-> occ == OCC_W'(1)); // R2
  AST_SLOW_MUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mul_slow_i && class_i == CLS_MUL) |-> occ == OCC_W'(MUL_SLOW_CYC)); // R4
  AST_BUSY_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != '0) |-> !ready_o); // R9
endmodule

// File: tb/issue_occ_ctrl_tb_top.sv
`timescale 1ns/1ps
module issue_occ_ctrl_tb_top;
  import issue_occ_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] cls = 4'd0;
  logic [3:0] words = 4'd0;
  logic       slow = 1'b0;
  logic       ready;
  logic [5:0] busy;

  int    checks = 0;
  int    failures = 0;
  int    m_rem = 0;
  bit    run = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  issue_occ_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .class_i(cls),
    .words_i(words), .mul_slow_i(slow), .ready_o(ready), .busy_o(busy)
  );

  function automatic int occ_ref(input int c, input int w, input bit s);
    case (c)
      5: return s ? 17 : 1;
      6: return s ? 18 : 2;
      7: return 37;
      8, 9: return ((w >= 1 && w <= 8) || w == 12) ? w : 1;
      10, 11: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rem = 0;
    else if (m_rem != 0) m_rem = m_rem - 1;
    else if (valid) m_rem = occ_ref(cls, words, slow) - 1;
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      chk(ready == (m_rem == 0), {cur_req, " R9 ready"}, ready, m_rem == 0);
      chk(int'(busy) == m_rem, {cur_req, " R10 busy"}, busy, m_rem);
    end
  end

  task automatic send(input int c, input int w, input bit s, input string req);
    cur_req = req;
    while (m_rem != 0) @(negedge clk);
    valid = 1'b1; cls = 4'(c); words = 4'(w); slow = s;
    @(negedge clk);
    valid = 1'b0;
    chk(int'(busy) == occ_ref(c, w, s) - 1, req, busy, occ_ref(c, w, s) - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && busy == 0, "R1 in reset", {ready, busy}, 64);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && busy == 0, "R1 after release", {ready, busy}, 64);
    run = 1'b1;

    // R2: back-to-back simple classes
    cur_req = "R2";
    for (int i = 0; i < 10; i++) begin
      valid = 1'b1; cls = 4'(i % 5); words = 4'd9;
      @(negedge clk);
      chk(ready == 1'b1, "R2 stream", ready, 1);
    end
    valid = 1'b0;

    send(CLS_MUL, 0, 1'b0, "R3 mul fast");
    send(CLS_MAC, 0, 1'b0, "R3 mac fast");
    send(CLS_MUL, 0, 1'b1, "R4 mul slow");
    send(CLS_MAC, 0, 1'b1, "R4 mac slow");
    send(CLS_DIV, 0, 1'b0, "R5 div fast cfg");
    send(CLS_DIV, 0, 1'b1, "R5 div slow cfg");

    for (int w = 0; w < 16; w++) begin
      send(CLS_LDM, w, 1'b0, "R6 ldm");
      send(CLS_STM, w, 1'b1, "R6 stm");
    end

    send(CLS_LDD, 7, 1'b0, "R7 ldd");
    send(CLS_STD, 12, 1'b1, "R7 std");
    send(CLS_STD, 0, 1'b0, "R7 std zero");

    for (int c = 12; c < 16; c++) send(c, 12, 1'b1, "R8 unknown");

    // R9: offers while busy are ignored
    send(CLS_DIV, 0, 1'b0, "R9 setup");
    valid = 1'b1; cls = CLS_DIV;
    repeat (10) @(negedge clk);
    valid = 1'b0;
    chk(int'(busy) == 26, "R9 ignored offers", busy, 26);

    // R11: configuration change while busy
    send(CLS_MAC, 0, 1'b1, "R11 setup");
    slow = 1'b0;
    repeat (5) @(negedge clk);
    chk(int'(busy) == 12, "R11 cfg flip", busy, 12);
    slow = 1'b1;
    send(CLS_MUL, 0, 1'b0, "R11 fast after flip");

    // mixed continuous stream
    cur_req = "R10 stream";
    for (int i = 0; i < 60; i++) begin
      valid = 1'b1; cls = 4'((i * 7) % 16); words = 4'((i * 5) % 16); slow = i[1];
      @(negedge clk);
    end
    valid = 1'b0;

    // R1: reset while busy
    send(CLS_DIV, 0, 1'b0, "R1 setup");
    repeat (4) @(negedge clk);
    run = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(busy == 0 && ready == 1'b1, "R1 async clear", {ready, busy}, 64);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && ready == 1'b1, "R1 restart", {ready, busy}, 64);
    run = 1'b1;
    send(CLS_MAC, 0, 1'b0, "R1 post reset");
    repeat (3) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule